// File: doc/BRIEF.md
# Programmable Serial Bit-Clock Divider

This block produces the bit clock for a synchronous serial port. It counts periods of a selected input clock and divides them by a programmable factor. The input clock is either a free-running quarter-rate copy of the system clock or an external clock pin. The external pin is brought into the system clock domain before it is used. An 8-bit divide value `DIV` sets the output period to `1 + DIV` input periods. The split between the high phase and the low phase depends on whether `DIV` is even or odd. `DIV = 0` passes the selected input clock straight through.

Besides the divided clock, the block gives two single-cycle strobes, one for each rising and one for each falling output transition, so that a shift register can move data in step without its own edge detection. The divide value and the input select are taken in only when the output clock rises. A reconfiguration therefore never shortens a phase that is already running.

Top module: `serclk_divider`

## Requirements
- R1: When `DIV` is 1 or more, the output period is exactly `(1 + DIV)` input-clock periods, counted on rising input transitions.
- R2: When `DIV` is even and nonzero, the high phase lasts `DIV/2 + 1` input periods and the low phase lasts `DIV/2` input periods.
- R3: When `DIV` is odd, the high and low phases each last `(DIV + 1)/2` input periods.
- R4: With `mode_internal = 1` the input clock is the system clock divided by four: each input period is 4 system cycles, high for 2 and low for 2.
- R5: With `mode_internal = 0` the input clock is `ext_clk`, passed through a two-flop synchronizer and edge-detected. For an external clock of period E system cycles, every phase width is a multiple of E.
- R6: When `DIV = 0` the output follows the selected input clock: high while it is high, low while it is low (2/2 cycles internal; E/2 and E/2 for a symmetric external clock).
- R7: A new `div_sel` or `mode_internal` value has no effect on the phases already running. It is captured at the next rising transition of `sclk_out` and governs the period that starts there.
- R8: `rise_stb` is high for exactly one system cycle: the first cycle in which `sclk_out` is 1 after being 0. `fall_stb` is high for the first cycle in which it is 0 after being 1. The two are never high together, and `sclk_out` never changes without one of them.
- R9: While `rst_n` is low, `sclk_out`, `rise_stb` and `fall_stb` are 0. After reset the first rising input transition raises `sclk_out` and captures the configuration.
- R10: `DIV = 1` with the internal input gives a symmetric 8-cycle output clock, high for 4 cycles and low for 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| mode_internal | input | 1 | 1: divide the quarter-rate system clock; 0: divide `ext_clk` |
| ext_clk | input | 1 | External input clock, asynchronous to `clk` |
| div_sel | input | 8 | Divide value `DIV` |
| sclk_out | output | 1 | Divided serial bit clock |
| rise_stb | output | 1 | One-cycle strobe on each rising transition of `sclk_out` |
| fall_stb | output | 1 | One-cycle strobe on each falling transition of `sclk_out` |

## Verification
Capturing a new configuration and raising the output clock happen in the same cycle. When the input select flips, that same rising transition also hands tick generation over to the other source. The bench provokes this by writing a new divide value, and separately a new input select, one cycle after a rising strobe. It then times the running period, which must keep the old high and low widths, and times the following period, which must show the new ones. After an input switch, the first full period under the new source is skipped, because its rising edge was timed by the old source. Sweeps over all small divide values, and the largest ones, in both modes compare every phase length against widths computed from the parity rule.

// File: rtl/serclk_pkg.sv
package serclk_pkg;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } sclk_phase_e;

endpackage

// File: rtl/serclk_tick_src.sv
module serclk_tick_src #(
  parameter int PRE_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_internal,
  input  logic ext_clk,
  output logic tick_rise,
  output logic tick_fall
);

  localparam int PCW = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
  localparam logic [PCW-1:0] PRE_LAST = PCW'(PRE_DIV - 1);
  localparam logic [PCW-1:0] PRE_HALF = PCW'(PRE_DIV / 2);

  logic [PCW-1:0]       pre_cnt;
  logic [SYNC_STAGES:0] ext_sh;
  logic                 ext_now;
  logic                 ext_prev;
  logic                 int_rise;
  logic                 int_fall;

  // free-running prescaler: one input period per PRE_DIV system cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pre_cnt <= '0;
    else if (pre_cnt == PRE_LAST) pre_cnt <= '0;
    else                       pre_cnt <= pre_cnt + 1'b1;
  end

  assign int_rise = (pre_cnt == '0);
  assign int_fall = (pre_cnt == PRE_HALF);

  // synchronizer chain plus one history stage for edge detection
  for (genvar g = 0; g <= SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ext_sh[g] <= 1'b0;
        else        ext_sh[g] <= ext_clk;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ext_sh[g] <= 1'b0;
        else        ext_sh[g] <= ext_sh[g-1];
      end
    end
  end

  assign ext_now  = ext_sh[SYNC_STAGES-1];
  assign ext_prev = ext_sh[SYNC_STAGES];

  assign tick_rise = sel_internal ? int_rise : (ext_now & ~ext_prev);
  assign tick_fall = sel_internal ? int_fall : (~ext_now & ext_prev);

endmodule

// File: rtl/serclk_phase_gen.sv
module serclk_phase_gen
  import serclk_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_rise,
  input  logic             tick_fall,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             mode_sel,
  output logic             sclk,
  output logic             rise_stb,
  output logic             fall_stb,
  output logic [DIV_W-1:0] div_act,
  output logic             mode_act
);

  // high phase length in input periods
  function automatic logic [DIV_W-1:0] hi_len(input logic [DIV_W-1:0] d);
    logic [DIV_W:0] s;
    s = {1'b0, d} + 1'b1;
    if (d[0]) return s[DIV_W:1];
    else      return {1'b0, d[DIV_W-1:1]} + 1'b1;
  endfunction

  // low phase length in input periods
  function automatic logic [DIV_W-1:0] lo_len(input logic [DIV_W-1:0] d);
    logic [DIV_W:0] s;
    s = {1'b0, d} + 1'b1;
    if (d[0]) return s[DIV_W:1];
    else      return {1'b0, d[DIV_W-1:1]};
  endfunction

  sclk_phase_e      phase_q;
  logic [DIV_W-1:0] cnt_q;
  logic             bypass;
  logic             last_tick;
  logic             go_rise;
  logic             go_fall;

  assign bypass    = (div_act == '0);
  assign last_tick = tick_rise && (cnt_q == DIV_W'(1));
  assign go_rise   = (phase_q == PH_LOW) && tick_rise && (bypass || cnt_q == DIV_W'(1));
  assign go_fall   = (phase_q == PH_HIGH) && (bypass ? tick_fall : last_tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_LOW;
      cnt_q    <= '0;
      div_act  <= '0;
      mode_act <= 1'b1;
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
    end else begin
      rise_stb <= go_rise;
      fall_stb <= go_fall;
      if (go_rise) begin
        phase_q  <= PH_HIGH;
        div_act  <= div_sel;
        mode_act <= mode_sel;
        cnt_q    <= hi_len(div_sel);
      end else if (go_fall) begin
        phase_q  <= PH_LOW;
        cnt_q    <= lo_len(div_act);
      end else if (tick_rise && cnt_q != '0) begin
        cnt_q    <= cnt_q - 1'b1;
      end
    end
  end

  assign sclk = (phase_q == PH_HIGH);

endmodule

// File: rtl/serclk_divider.sv
module serclk_divider #(
  parameter int DIV_W       = 8,
  parameter int PRE_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_internal,
  input  logic             ext_clk,
  input  logic [DIV_W-1:0] div_sel,
  output logic             sclk_out,
  output logic             rise_stb,
  output logic             fall_stb
);

  // internal events brought out for the checker
  logic             tick_rise;
  logic             tick_fall;
  logic             mode_act;
  logic [DIV_W-1:0] div_act;

  serclk_tick_src #(
    .PRE_DIV     (PRE_DIV),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_src (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_internal (mode_act),
    .ext_clk      (ext_clk),
    .tick_rise    (tick_rise),
    .tick_fall    (tick_fall)
  );

  serclk_phase_gen #(
    .DIV_W (DIV_W)
  ) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_rise (tick_rise),
    .tick_fall (tick_fall),
    .div_sel   (div_sel),
    .mode_sel  (mode_internal),
    .sclk      (sclk_out),
    .rise_stb  (rise_stb),
    .fall_stb  (fall_stb),
    .div_act   (div_act),
    .mode_act  (mode_act)
  );

endmodule

// File: rtl/serclk_divider_chk.sv
module serclk_divider_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sclk_out,
  input logic             rise_stb,
  input logic             fall_stb,
  input logic             tick_rise,
  input logic             tick_fall,
  input logic             mode_act,
  input logic [DIV_W-1:0] div_act
);

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb && fall_stb));

  assert_rise_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> (sclk_out && !$past(sclk_out)));

  assert_fall_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> (!sclk_out && $past(sclk_out)));

  assert_edge_flagged_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_out != $past(sclk_out)) |-> (rise_stb || fall_stb));

  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_stb |-> ($stable(div_act) && $stable(mode_act)));

  assert_rise_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> $past(tick_rise));

  assert_fall_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> $past(tick_rise || tick_fall));

endmodule

bind serclk_divider serclk_divider_chk #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sclk_out  (sclk_out),
  .rise_stb  (rise_stb),
  .fall_stb  (fall_stb),
  .tick_rise (tick_rise),
  .tick_fall (tick_fall),
  .mode_act  (mode_act),
  .div_act   (div_act)
);

// File: tb/serclk_divider_bench.sv
module serclk_divider_bench;

  localparam int CLK_PERIOD = 10;
  localparam int EXT_HALF   = 3;
  localparam int INT_PER    = 4;
  localparam int EXT_PER    = 2 * EXT_HALF;
  localparam int TIMEOUT    = 4000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_internal = 1'b1;
  logic       ext_clk = 1'b0;
  logic [7:0] div_sel = 8'd0;
  logic       sclk_out;
  logic       rise_stb;
  logic       fall_stb;

  int checks = 0;
  int fails  = 0;

  serclk_divider u_serclk_divider (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_internal (mode_internal),
    .ext_clk       (ext_clk),
    .div_sel       (div_sel),
    .sclk_out      (sclk_out),
    .rise_stb      (rise_stb),
    .fall_stb      (fall_stb)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    forever begin
      repeat (EXT_HALF) @(negedge clk);
      ext_clk = ~ext_clk;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // leaves the bench at the negedge where rise_stb is first seen
  task automatic wait_rise();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!rise_stb && n < TIMEOUT);
    if (!rise_stb) check(1'b0, "R1", "timeout waiting for rising strobe", n, 0);
  endtask

  // Starts at a negedge showing rise_stb; times one high and one low phase.
  task automatic phase_pair(input int d, input int per, input string src);
    int h = 0;
    int l = 0;
    int hi_exp;
    int lo_exp;
    bit stray = 1'b0;
    string par;
    if (d == 0) begin
      hi_exp = per / 2;
      lo_exp = per / 2;
      par = "R6";
    end else begin
      hi_exp = per * ((d + 2) / 2);
      lo_exp = per * ((d + 1) / 2);
      par = (d % 2 == 0) ? "R2" : "R3";
    end
    check(sclk_out == 1'b1 && fall_stb == 1'b0, "R8", "sclk high with rising strobe", int'(sclk_out), 1);
    do begin
      @(negedge clk);
      h++;
      if (rise_stb) stray = 1'b1;
    end while (!fall_stb && h < TIMEOUT);
    check(sclk_out == 1'b0 && rise_stb == 1'b0, "R8", "sclk low with falling strobe", int'(sclk_out), 0);
    do begin
      @(negedge clk);
      l++;
      if (fall_stb) stray = 1'b1;
    end while (!rise_stb && l < TIMEOUT);
    check(!stray, "R8", $sformatf("single strobe per edge DIV=%0d", d), int'(stray), 0);
    check(h == hi_exp, par, $sformatf("%s high phase DIV=%0d", src, d), h, hi_exp);
    check(l == lo_exp, par, $sformatf("%s low phase DIV=%0d", src, d), l, lo_exp);
    if (d != 0)
      check(h + l == per * (1 + d), "R1", $sformatf("%s period DIV=%0d", src, d), h + l, per * (1 + d));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R9: reset state
    repeat (5) @(negedge clk);
    check(sclk_out == 1'b0, "R9", "sclk in reset", int'(sclk_out), 0);
    check(rise_stb == 1'b0 && fall_stb == 1'b0, "R9", "strobes in reset",
          int'(rise_stb) + int'(fall_stb), 0);
    div_sel = 8'd3;
    rst_n = 1'b1;
    begin
      int n = 0;
      do begin @(negedge clk); n++; end while (!rise_stb && n < 20);
      // first internal rising tick: prescaler at zero in the first cycle after release
      check(n <= INT_PER + 1, "R9", "cycles to first rising edge after reset", n, INT_PER + 1);
    end
    phase_pair(3, INT_PER, "R9 first");

    // R4, R2, R3, R6: internal sweep; the first rise after each write captures it
    for (int d = 0; d <= 40; d++) begin
      div_sel = 8'(d);
      wait_rise();
      phase_pair(d, INT_PER, "R4 internal");
    end
    begin
      int big[4] = '{127, 128, 254, 255};
      foreach (big[i]) begin
        div_sel = 8'(big[i]);
        wait_rise();
        phase_pair(big[i], INT_PER, "R4 internal");
      end
    end

    // R10: DIV = 1 gives 4/4 cycles
    div_sel = 8'd1;
    wait_rise();
    begin
      int h = 0;
      do begin @(negedge clk); h++; end while (!fall_stb && h < TIMEOUT);
      check(h == 4, "R10", "DIV=1 high cycles", h, 4);
      h = 0;
      do begin @(negedge clk); h++; end while (!rise_stb && h < TIMEOUT);
      check(h == 4, "R10", "DIV=1 low cycles", h, 4);
    end

    // R7: divide change one cycle into the high phase
    div_sel = 8'd2;
    wait_rise();
    phase_pair(2, INT_PER, "R7 before");
    @(negedge clk);
    div_sel = 8'd5;
    begin
      int h = 1;
      int l = 0;
      do begin @(negedge clk); h++; end while (!fall_stb && h < TIMEOUT);
      do begin @(negedge clk); l++; end while (!rise_stb && l < TIMEOUT);
      check(h == INT_PER * 2, "R7", "running high keeps old DIV", h, INT_PER * 2);
      check(l == INT_PER * 1, "R7", "running low keeps old DIV", l, INT_PER);
    end
    phase_pair(5, INT_PER, "R7 after");

    // R7, R5: input switch one cycle into the high phase
    div_sel = 8'd3;
    wait_rise();
    @(negedge clk);
    mode_internal = 1'b0;
    begin
      int h = 1;
      int l = 0;
      do begin @(negedge clk); h++; end while (!fall_stb && h < TIMEOUT);
      do begin @(negedge clk); l++; end while (!rise_stb && l < TIMEOUT);
      check(h == INT_PER * 2 && l == INT_PER * 2, "R7", "period running at switch stays internal",
            h + l, INT_PER * 4);
    end
    wait_rise();
    for (int d = 0; d <= 8; d++) begin
      div_sel = 8'(d);
      wait_rise();
      if (d == 0) wait_rise();
      phase_pair(d, EXT_PER, "R5 external");
    end

    // back to internal: one settling period, then internal widths again
    div_sel = 8'd4;
    mode_internal = 1'b1;
    wait_rise();
    wait_rise();
    phase_pair(4, INT_PER, "R4 return");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule